// File: doc/BRIEF.md
# Instruction-Cycle Timer/Counter with Steerable Prescaler

The block is an 8-bit up-counter that software reads and writes like a register. It counts either internal instruction cycles or edges of an external clock pin. An instruction cycle is four system clocks. The external pin is resampled once per instruction cycle through a two-stage synchronizer. A one-cycle enable pulse is then produced for each edge of the chosen polarity.

A single 8-bit prescaler serves two destinations, chosen by one control bit. It can sit ahead of the counter and divide the count source by 2 to 256. Otherwise it divides the instruction-cycle strobe and emits a watchdog tick. In that case the counter runs at 1:1.

A rollover from FFh to 00h latches an overflow flag. The flag stays set until software clears it. The flag ANDed with an interrupt-enable bit drives the interrupt output.

A write to the count starts a small hold sequencer with states ST_RUN, ST_HOLD1 and ST_HOLD2. The sequencer moves as follows:
- A count write from any state moves it to ST_HOLD1.
- An instruction-cycle strobe moves ST_HOLD1 to ST_HOLD2.
- The next strobe moves ST_HOLD2 back to ST_RUN.
- The sequencer stays in ST_RUN until the next count write.

While the sequencer is outside ST_RUN, the count source is gated off.

Top module: `cyc_timer8`

## Requirements
- R1: After reset the outputs are as follows: cnt_q is 00h, ovf_flag, irq, ien_q and wdt_tick are 0, and ctl_q is 3Fh. The control layout is ctl[0] external source, ctl[1] falling-edge select, ctl[2] prescaler-to-watchdog, ctl[5:3] ratio select k.
- R2: With ctl[0]=0 and ctl[2]=1, the count rises by exactly one per instruction cycle (four clocks).
- R3: A cnt_we pulse loads cnt_wdata. The next two instruction-cycle strobes produce no increment, so N cycles after a write the count is data+N-2.
- R4: With ctl[0]=1 and ctl[1]=0, each rising edge of ext_pin adds one and falling edges add nothing.
- R5: With ctl[0]=1 and ctl[1]=1, each falling edge of ext_pin adds one and rising edges add nothing.
- R6: ext_pin is resampled through two stages on instruction-cycle strobes. A selected edge therefore shows in cnt_q after more than four clocks and no later than twelve.
- R7: With ctl[2]=0, the counter advances once per 2^(k+1) source events. A count write clears the prescaler's partial count.
- R8: With ctl[2]=1, wdt_tick pulses for one clock every 2^(k+1) instruction cycles. With ctl[2]=0, wdt_tick stays 0.
- R9: A rollover from FFh to 00h sets ovf_flag. The flag holds until a flag_clr pulse, and a set in the same clock wins over the clear.
- R10: irq is ovf_flag AND ien_q. Clearing ien_q drops irq and leaves ovf_flag unchanged.
- R11: ctl_we loads ctl_wdata, and the loaded value reads back on ctl_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External count clock, asynchronous |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Count write value |
| cnt_q | output | 8 | Current count |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 6 | Control write value |
| ctl_q | output | 6 | Control readback |
| ien_we | input | 1 | Interrupt-enable write strobe |
| ien_wdata | input | 1 | Interrupt-enable write value |
| ien_q | output | 1 | Interrupt-enable readback |
| flag_clr | input | 1 | Overflow flag clear pulse |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request |
| wdt_tick | output | 1 | Watchdog-path prescaler tick |

## Verification
The counting core is exercised in several ways:
- The internal strobe at 1:1 shows the two-cycle hold after a write.
- Ratios 1:2 and 1:8 show the divide law.
- A mid-count rewrite tells a cleared prescaler from a stale one.

The external path is driven with slow pulse trains in both edge polarities. The pin is sampled half-way through a pulse, which separates the counting edge from the ignored one. The synchronizer is checked after a single edge, once early and once at the latest allowed point, which pins its latency. The watchdog steering is covered by counting tick pulses over fixed windows at two ratios and with the prescaler given back to the counter.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_HOLD1 = 2'd1,
        ST_HOLD2 = 2'd2
    } hold_state_t;

    // packed: first member is the most significant field
    typedef struct packed {
        logic [2:0] ratio;
        logic       to_wdt;
        logic       fall_edge;
        logic       ext_src;
    } ctl_t;

    localparam int CTL_W = 6;
    localparam logic [CTL_W-1:0] CTL_RESET = 6'h3F;

endpackage

// File: rtl/tc_cycle_gen.sv
module tc_cycle_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic cyc_stb
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                    phase <= phase + 1'b1;
    end

    assign cyc_stb = (phase == LAST);
endmodule

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_stb,
    input  logic pin,
    input  logic fall_sel,
    output logic edge_pulse
);
    // sh[STAGES-1:0] synchronizer, sh[STAGES] previous synchronized level
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       sh <= '0;
        else if (cyc_stb) sh <= {sh[STAGES-1:0], pin ^ fall_sel};
    end

    assign edge_pulse = cyc_stb & sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
    parameter int PSC_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_pulse,
    input  logic [SEL_W-1:0] ratio,
    output logic             out_pulse
);
    logic [PSC_W-1:0] cnt;
    logic [PSC_W-1:0] mask;

    // ratio k selects a terminal count of 2^(k+1)
    always_comb begin
        for (int i = 0; i < PSC_W; i++) begin
            mask[i] = (i <= int'(ratio));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clr)      cnt <= '0;
        else if (in_pulse) cnt <= cnt + 1'b1;
    end

    assign out_pulse = in_pulse & ~clr & ((cnt & mask) == mask);
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_stb,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             inc,
    input  logic             flag_clr,
    output logic             inhibit,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] TOP = '1;

    hold_state_t state, state_nx;
    logic        wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (wr) begin
            state_nx = ST_HOLD1;
        end else if (cyc_stb) begin
            unique case (state)
                ST_RUN:   state_nx = ST_RUN;
                ST_HOLD1: state_nx = ST_HOLD2;
                ST_HOLD2: state_nx = ST_RUN;
                default:  state_nx = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_RUN:   inhibit = 1'b0;
            ST_HOLD1: inhibit = 1'b1;
            ST_HOLD2: inhibit = 1'b1;
            default:  inhibit = 1'b1;
        endcase
    end

    assign wrap = inc & ~wr & (count == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (wr)  count <= wr_data;
        else if (inc) count <= count + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/cyc_timer8.sv
module cyc_timer8
    import cyc_timer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSC_W       = 8,
    parameter int CYC_DIV     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             ien_we,
    input  logic             ien_wdata,
    output logic             ien_q,
    input  logic             flag_clr,
    output logic             ovf_flag,
    output logic             irq,
    output logic             wdt_tick
);
    ctl_t ctl;
    logic ien;
    logic cyc_stb, ext_edge, src_pulse, gated_src, inhibit;
    logic psc_in, psc_out, psc_clr, cnt_inc, tick_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl <= ctl_t'(CTL_RESET);
        else if (ctl_we) ctl <= ctl_t'(ctl_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien <= 1'b0;
        else if (ien_we) ien <= ien_wdata;
    end

    tc_cycle_gen #(.DIV(CYC_DIV)) u_cyc (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_stb (cyc_stb)
    );

    tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_stb    (cyc_stb),
        .pin        (ext_pin),
        .fall_sel   (ctl.fall_edge),
        .edge_pulse (ext_edge)
    );

    assign src_pulse = ctl.ext_src ? ext_edge : cyc_stb;
    assign gated_src = src_pulse & ~inhibit;

    // prescaler steering: watchdog path divides raw strobes
    assign psc_in  = ctl.to_wdt ? cyc_stb : gated_src;
    assign psc_clr = cnt_we & ~ctl.to_wdt;
    assign cnt_inc = ctl.to_wdt ? gated_src : psc_out;

    tc_prescaler #(.PSC_W(PSC_W), .SEL_W(3)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (psc_clr),
        .in_pulse  (psc_in),
        .ratio     (ctl.ratio),
        .out_pulse (psc_out)
    );

    tc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_stb  (cyc_stb),
        .wr       (cnt_we),
        .wr_data  (cnt_wdata),
        .inc      (cnt_inc),
        .flag_clr (flag_clr),
        .inhibit  (inhibit),
        .count    (cnt_q),
        .flag     (ovf_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_r <= 1'b0;
        else        tick_r <= psc_out & ctl.to_wdt;
    end

    assign wdt_tick = tick_r;
    assign ctl_q    = ctl;
    assign ien_q    = ien;
    assign irq      = ovf_flag & ien;
endmodule

// File: rtl/cyc_timer8_chk.sv
module cyc_timer8_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cnt_we,
    input logic [7:0] cnt_wdata,
    input logic [7:0] cnt_q,
    input logic [5:0] ctl_q,
    input logic       ien_q,
    input logic       ovf_flag,
    input logic       irq,
    input logic       wdt_tick
);
    assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_we) |-> cnt_q == $past(cnt_wdata));

    assert_hold_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_we) && !cnt_we) |=> $stable(cnt_q));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cnt_we) |-> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 8'd1));

    assert_flag_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == 8'h00 && $past(cnt_q) == 8'hFF && !$past(cnt_we)) |-> ovf_flag);

    assert_flag_rise_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> cnt_q == 8'h00);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q |-> !irq);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_flag);

    assert_tick_only_wdt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick |-> $past(ctl_q[2]));

    assert_tick_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_tick |=> !wdt_tick);
endmodule

bind cyc_timer8 cyc_timer8_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_q),
    .ctl_q     (ctl_q),
    .ien_q     (ien_q),
    .ovf_flag  (ovf_flag),
    .irq       (irq),
    .wdt_tick  (wdt_tick)
);

// File: tb/tb_cyc_timer8.sv
module tb_cyc_timer8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_q;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic [5:0] ctl_q;
    logic       ien_we = 1'b0;
    logic       ien_wdata = 1'b0;
    logic       ien_q;
    logic       flag_clr = 1'b0;
    logic       ovf_flag, irq, wdt_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cyc_timer8 dut (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_wdata = v; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_wdata = v; cnt_we = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wr_ien(input logic v);
        ien_wdata = v; ien_we = 1'b1;
        @(negedge clk);
        ien_we = 1'b0;
    endtask

    task automatic pulse_pin();
        ext_pin = 1'b1; clocks(20);
        ext_pin = 1'b0; clocks(20);
    endtask

    task automatic t_reset();
        check("R1", "cnt_q", cnt_q, 8'h00);
        check("R1", "ovf_flag", ovf_flag, 0);
        check("R1", "irq", irq, 0);
        check("R1", "ien_q", ien_q, 0);
        check("R1", "wdt_tick", wdt_tick, 0);
        check("R1", "ctl_q", ctl_q, 6'h3F);
    endtask

    task automatic t_timer();
        wr_ctl(6'b000100);
        check("R11", "ctl readback", ctl_q, 6'b000100);
        wr_cnt(8'h10);
        check("R3", "loaded", cnt_q, 8'h10);
        clocks(4);
        check("R3", "hold cycle 1", cnt_q, 8'h10);
        clocks(4);
        check("R3", "hold cycle 2", cnt_q, 8'h10);
        clocks(20);
        check("R2", "1:1 after 5 cycles", cnt_q, 8'h15);
    endtask

    task automatic t_prescale();
        wr_ctl(6'b010000);                 // to counter, k=2 -> 1:8
        wr_cnt(8'h20);
        clocks(4 * 26);
        check("R7", "1:8", cnt_q, 8'h23);
        wr_ctl(6'b000000);                 // k=0 -> 1:2
        wr_cnt(8'h40);
        clocks(4 * 12);
        check("R7", "1:2", cnt_q, 8'h45);
        wr_ctl(6'b010000);
        wr_cnt(8'h50);
        clocks(4 * 7);
        wr_cnt(8'h50);                     // must clear partial prescale
        clocks(4 * 9);
        check("R7", "prescaler cleared by write", cnt_q, 8'h50);
    endtask

    task automatic t_overflow();
        wr_ctl(6'b000100);
        wr_ien(1'b1);
        wr_cnt(8'hFE);
        clocks(12);
        check("R9", "at FF", cnt_q, 8'hFF);
        check("R9", "flag before wrap", ovf_flag, 0);
        clocks(4);
        check("R9", "wrapped", cnt_q, 8'h00);
        check("R9", "flag set", ovf_flag, 1);
        check("R10", "irq on", irq, 1);
        clocks(40);
        check("R9", "flag sticky", ovf_flag, 1);
        wr_ien(1'b0);
        check("R10", "irq masked", irq, 0);
        check("R10", "flag kept when masked", ovf_flag, 1);
        wr_ien(1'b1);
        check("R10", "irq back", irq, 1);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check("R9", "flag cleared", ovf_flag, 0);
        check("R10", "irq after clear", irq, 0);
    endtask

    task automatic t_wdt();
        int n;
        wr_ctl(6'b000100);                 // to watchdog, k=0
        clocks(40);
        n = 0;
        for (int i = 0; i < 80; i++) begin @(negedge clk); n += int'(wdt_tick); end
        check("R8", "ticks 1:2 in 80 clk", n, 10);
        wr_ctl(6'b010100);                 // k=2
        clocks(64);
        n = 0;
        for (int i = 0; i < 128; i++) begin @(negedge clk); n += int'(wdt_tick); end
        check("R8", "ticks 1:8 in 128 clk", n, 4);
        wr_ctl(6'b000000);
        clocks(8);
        n = 0;
        for (int i = 0; i < 80; i++) begin @(negedge clk); n += int'(wdt_tick); end
        check("R8", "no ticks when to counter", n, 0);
    endtask

    task automatic t_ext_rise();
        ext_pin = 1'b0;
        wr_ctl(6'b000101);
        clocks(40);
        wr_cnt(8'h00);
        clocks(16);
        for (int i = 0; i < 5; i++) pulse_pin();
        clocks(24);
        check("R4", "5 rising edges", cnt_q, 8'h05);
        ext_pin = 1'b1;
        clocks(4);
        check("R6", "not yet through sync", cnt_q, 8'h05);
        clocks(8);
        check("R6", "seen within 12 clk", cnt_q, 8'h06);
        clocks(20);
        ext_pin = 1'b0;
        clocks(24);
        check("R4", "falling edge ignored", cnt_q, 8'h06);
    endtask

    task automatic t_ext_fall();
        ext_pin = 1'b0;
        wr_ctl(6'b000111);
        clocks(40);
        wr_cnt(8'h00);
        clocks(16);
        for (int i = 0; i < 4; i++) pulse_pin();
        clocks(24);
        check("R5", "4 falling edges", cnt_q, 8'h04);
        ext_pin = 1'b1;
        clocks(20);
        check("R5", "rising edge ignored", cnt_q, 8'h04);
        ext_pin = 1'b0;
        clocks(24);
        check("R5", "falling edge counted", cnt_q, 8'h05);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        clocks(3);
        t_reset();
        rst_n = 1'b1;
        clocks(2);
        t_timer();
        t_prescale();
        t_overflow();
        t_wdt();
        t_ext_rise();
        t_ext_fall();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule